// File: doc/BRIEF.md
# Issue-stage interlock and occupancy scoreboard

This block is the stall controller of a single-issue, in-order pipeline whose issue stage also performs execution. Each cycle it looks at the micro-operation waiting at issue and decides whether it may go. Two things can hold it back. The issue unit may still be occupied by an earlier multi-cycle operation such as a divide, a multiply-accumulate, or a multiply when the slow multiplier is strapped in. The candidate may also read a register that a recent load is still filling. Load data arrives one stage after issue, and every consumer wants its operands at issue, so a dependent micro-operation must issue at least two cycles after the load.

The candidate arrives on a valid/ready pair. `uop_valid_i` marks a micro-operation present, and `issue_en_o` acts as ready. A micro-operation issues on a rising clock edge where both are high. While `issue_en_o` is low the sender holds the micro-operation and its fields stable, and it may drop or change them only after an accepting edge. `issue_en_o` may be high while `uop_valid_i` is low. A stall reason is reported on a plain status pin. A writeback notice names a register whose value has reached the register file, which releases any wait on that register in the same cycle. The datapath, the forwarding multiplexers and branch resolution live elsewhere.

Top module: `issue_gate`

## Requirements
- R1: After reset, with no candidate presented, `issue_en_o` is 1 and `stall_why_o` is 00.
- R2: Class codes 0 (ALU), 1 (branch), 2 (load), 3 (store), 4 (load-multiple word), 5 (store-multiple word), 6 (base update) and all unused codes 10 to 15 hold the issue unit for one cycle, so an independent follower issues on the next edge.
- R3: With `slow_mul_i` = 1, a multiply (code 7) holds the issue unit for 17 cycles and a multiply-accumulate (code 8) for 18 cycles. The follower issues that many cycles after the operation.
- R4: With `slow_mul_i` = 0, a multiply holds the issue unit for 1 cycle and a multiply-accumulate for 2.
- R5: A divide (code 9) holds the issue unit for 37 cycles in either multiplier mode.
- R6: While the issue unit is held, `issue_en_o` is 0 and `stall_why_o` is 01 whatever `uop_valid_i` is. Busy takes precedence over load-use.
- R7: After a load (code 2) with destination d ≠ 0 issues, a valid candidate in the next cycle whose `uop_rs1_i` or `uop_rs2_i` equals d sees `issue_en_o` = 0 and `stall_why_o` = 10. One cycle later, which is a distance of 2 from the load, it issues.
- R8: A load-multiple word (code 4) creates the load-use wait only when `uop_last_i` = 1. Earlier words of the sequence create none.
- R9: A base update (code 6), and every class other than load and last load-multiple word, never causes a load-use stall for a following consumer.
- R10: Register 0 is never a dependency. A load to register 0 creates no wait, and a source of 0 never matches.
- R11: If `wb_valid_i` is high with `wb_rd_i` equal to the waited-on register in the cycle the consumer is presented, no load-use stall is raised for that register.
- R12: `stall_why_o` only takes the values 00 (none), 01 (busy) and 10 (load-use). `issue_en_o` is 1 exactly when it is 00, and with `uop_valid_i` low it is never 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_mul_i | input | 1 | Multiplier strap: 1 = slow iterative, 0 = fast |
| uop_valid_i | input | 1 | Candidate micro-operation present |
| uop_class_i | input | 4 | Operation class code (see R2 to R9) |
| uop_rs1_i | input | 5 | First source register, 0 if unused |
| uop_rs2_i | input | 5 | Second source register, 0 if unused |
| uop_rd_i | input | 5 | Destination register |
| uop_last_i | input | 1 | Last word of a load-multiple sequence |
| wb_valid_i | input | 1 | Writeback notice valid |
| wb_rd_i | input | 5 | Register being written back |
| issue_en_o | output | 1 | Ready: candidate issues on this edge if valid |
| stall_why_o | output | 2 | 00 none, 01 busy, 10 load-use |

## Verification
The bench builds the block with its default values: 32 registers, a load-use distance of 2, and occupancies of 17, 18, 1, 2 and 37. At these sizes every class code in both multiplier modes can be swept, and the stall run behind each one can be counted against the arithmetic occupancy. Every one of the 32 load destinations is tried against both source positions. The small register count and single-entry load window also make the load-multiple last-word rule, the base-update exemption and the writeback release directly reachable.

// File: rtl/iss_pkg.sv
package iss_pkg;

  typedef enum logic [3:0] {
    OP_ALU    = 4'd0,
    OP_BRANCH = 4'd1,
    OP_LOAD   = 4'd2,
    OP_STORE  = 4'd3,
    OP_LDM    = 4'd4,
    OP_STM    = 4'd5,
    OP_BASE   = 4'd6,
    OP_MUL    = 4'd7,
    OP_MAC    = 4'd8,
    OP_DIV    = 4'd9
  } op_class_e;

  typedef enum logic [1:0] {
    WHY_NONE    = 2'b00,
    WHY_BUSY    = 2'b01,
    WHY_LOADUSE = 2'b10
  } stall_why_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/iss_occ_decode.sv
module iss_occ_decode #(
  parameter int unsigned CNT_W        = 6,
  parameter int unsigned MUL_SLOW_CYC = 17,
  parameter int unsigned MAC_SLOW_CYC = 18,
  parameter int unsigned MUL_FAST_CYC = 1,
  parameter int unsigned MAC_FAST_CYC = 2,
  parameter int unsigned DIV_CYC      = 37
) (
  input  logic [3:0]       op_class,
  input  logic             slow_mul,
  input  logic             last_word,
  output logic [CNT_W-1:0] hold_m1,
  output logic             late_result
);
  import iss_pkg::*;

  // extra cycles beyond the first one each class keeps the issue unit
  localparam logic [CNT_W-1:0] MUL_S_M1 = CNT_W'(MUL_SLOW_CYC - 1);
  localparam logic [CNT_W-1:0] MAC_S_M1 = CNT_W'(MAC_SLOW_CYC - 1);
  localparam logic [CNT_W-1:0] MUL_F_M1 = CNT_W'(MUL_FAST_CYC - 1);
  localparam logic [CNT_W-1:0] MAC_F_M1 = CNT_W'(MAC_FAST_CYC - 1);
  localparam logic [CNT_W-1:0] DIV_M1   = CNT_W'(DIV_CYC - 1);

  always_comb begin
    hold_m1     = '0;
    late_result = 1'b0;
    case (op_class)
      OP_MUL:  hold_m1 = slow_mul ? MUL_S_M1 : MUL_F_M1;
      OP_MAC:  hold_m1 = slow_mul ? MAC_S_M1 : MAC_F_M1;
      OP_DIV:  hold_m1 = DIV_M1;
      OP_LOAD: late_result = 1'b1;
      OP_LDM:  late_result = last_word;
      default: begin
        hold_m1     = '0;
        late_result = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/iss_busy_timer.sv
module iss_busy_timer #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load_en) begin
      remain_q <= load_val;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign busy = (remain_q != '0);

endmodule

// File: rtl/iss_late_tracker.sv
module iss_late_tracker #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [REG_W-1:0] push_rd,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic             wb_valid,
  input  logic [REG_W-1:0] wb_rd,
  output logic             hazard
);

  // slot k holds a load issued k+1 cycles ago
  logic [DEPTH-1:0] slot_v;
  logic [REG_W-1:0] slot_rd [DEPTH];
  logic [DEPTH-1:0] slot_live;
  logic [DEPTH-1:0] slot_hit;

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    assign slot_live[k] = slot_v[k] && !(wb_valid && (wb_rd == slot_rd[k]));
    assign slot_hit[k]  = slot_live[k] &&
                          (((src_a == slot_rd[k]) && (src_a != '0)) ||
                           ((src_b == slot_rd[k]) && (src_b != '0)));

    if (k == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_v[0]  <= 1'b0;
          slot_rd[0] <= '0;
        end else begin
          slot_v[0]  <= push && (push_rd != '0);
          slot_rd[0] <= push_rd;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_v[k]  <= 1'b0;
          slot_rd[k] <= '0;
        end else begin
          slot_v[k]  <= slot_live[k-1];
          slot_rd[k] <= slot_rd[k-1];
        end
      end
    end
  end

  assign hazard = |slot_hit;

endmodule

// File: rtl/issue_gate.sv
module issue_gate #(
  parameter int unsigned NREG         = 32,
  parameter int unsigned LOAD_DIST    = 2,
  parameter int unsigned MUL_SLOW_CYC = 17,
  parameter int unsigned MAC_SLOW_CYC = 18,
  parameter int unsigned MUL_FAST_CYC = 1,
  parameter int unsigned MAC_FAST_CYC = 2,
  parameter int unsigned DIV_CYC      = 37
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    slow_mul_i,
  input  logic                    uop_valid_i,
  input  logic [3:0]              uop_class_i,
  input  logic [$clog2(NREG)-1:0] uop_rs1_i,
  input  logic [$clog2(NREG)-1:0] uop_rs2_i,
  input  logic [$clog2(NREG)-1:0] uop_rd_i,
  input  logic                    uop_last_i,
  input  logic                    wb_valid_i,
  input  logic [$clog2(NREG)-1:0] wb_rd_i,
  output logic                    issue_en_o,
  output logic [1:0]              stall_why_o
);
  import iss_pkg::*;

  localparam int unsigned REG_W   = $clog2(NREG);
  localparam int unsigned MAX_CYC = max_of(max_of(max_of(MUL_SLOW_CYC, MAC_SLOW_CYC),
                                                  max_of(MUL_FAST_CYC, MAC_FAST_CYC)),
                                           DIV_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam int unsigned DEPTH   = (LOAD_DIST > 1) ? LOAD_DIST - 1 : 1;

  logic             busy;
  logic             hazard;
  logic             fire;
  logic [CNT_W-1:0] hold_m1;
  logic             late_result;
  stall_why_e       why;

  iss_occ_decode #(
    .CNT_W       (CNT_W),
    .MUL_SLOW_CYC(MUL_SLOW_CYC),
    .MAC_SLOW_CYC(MAC_SLOW_CYC),
    .MUL_FAST_CYC(MUL_FAST_CYC),
    .MAC_FAST_CYC(MAC_FAST_CYC),
    .DIV_CYC     (DIV_CYC)
  ) u_dec (
    .op_class   (uop_class_i),
    .slow_mul   (slow_mul_i),
    .last_word  (uop_last_i),
    .hold_m1    (hold_m1),
    .late_result(late_result)
  );

  iss_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (fire),
    .load_val(hold_m1),
    .busy    (busy)
  );

  iss_late_tracker #(.REG_W(REG_W), .DEPTH(DEPTH)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (fire && late_result),
    .push_rd (uop_rd_i),
    .src_a   (uop_rs1_i),
    .src_b   (uop_rs2_i),
    .wb_valid(wb_valid_i),
    .wb_rd   (wb_rd_i),
    .hazard  (hazard)
  );

  always_comb begin
    if (busy)                        why = WHY_BUSY;
    else if (uop_valid_i && hazard)  why = WHY_LOADUSE;
    else                             why = WHY_NONE;
  end

  assign issue_en_o  = (why == WHY_NONE);
  assign stall_why_o = why;
  assign fire        = uop_valid_i && issue_en_o;

endmodule

// File: rtl/iss_gate_chk.sv
module iss_gate_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slow_mul_i,
  input logic             uop_valid_i,
  input logic [3:0]       uop_class_i,
  input logic [REG_W-1:0] uop_rs1_i,
  input logic [REG_W-1:0] uop_rs2_i,
  input logic [REG_W-1:0] uop_rd_i,
  input logic             wb_valid_i,
  input logic [REG_W-1:0] wb_rd_i,
  input logic             issue_en_o,
  input logic [1:0]       stall_why_o
);

  logic fire;
  assign fire = uop_valid_i && issue_en_o;

  // R12
  reason_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_why_o != 2'b11) && (!uop_valid_i -> stall_why_o != 2'b10));

  // R5
  div_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && uop_class_i == 4'd9) |=> (!issue_en_o && stall_why_o == 2'b01));

  // R3
  slow_mac_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && uop_class_i == 4'd8 && slow_mul_i) |=> (stall_why_o == 2'b01));

  // R4
  fast_mul_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && uop_class_i == 4'd7 && !slow_mul_i) |=> (stall_why_o != 2'b01));

  // R7
  load_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fire && uop_class_i == 4'd2 && uop_rd_i != '0) && uop_valid_i &&
     uop_rs1_i == $past(uop_rd_i) && !(wb_valid_i && wb_rd_i == uop_rs1_i))
    |-> (stall_why_o == 2'b10));

  // R9
  base_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && uop_class_i == 4'd6) |=> (stall_why_o != 2'b10));

  // R10
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_rs1_i == '0 && uop_rs2_i == '0) |-> (stall_why_o != 2'b10));

endmodule

bind issue_gate iss_gate_chk #(.REG_W(REG_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .slow_mul_i (slow_mul_i),
  .uop_valid_i(uop_valid_i),
  .uop_class_i(uop_class_i),
  .uop_rs1_i  (uop_rs1_i),
  .uop_rs2_i  (uop_rs2_i),
  .uop_rd_i   (uop_rd_i),
  .wb_valid_i (wb_valid_i),
  .wb_rd_i    (wb_rd_i),
  .issue_en_o (issue_en_o),
  .stall_why_o(stall_why_o)
);

// File: tb/issue_gate_tb_top.sv
`timescale 1ns/1ps
module issue_gate_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_mul_i = 1'b0;
  logic       uop_valid_i = 1'b0;
  logic [3:0] uop_class_i = '0;
  logic [4:0] uop_rs1_i = '0;
  logic [4:0] uop_rs2_i = '0;
  logic [4:0] uop_rd_i = '0;
  logic       uop_last_i = 1'b0;
  logic       wb_valid_i = 1'b0;
  logic [4:0] wb_rd_i = '0;
  logic       issue_en_o;
  logic [1:0] stall_why_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  issue_gate dut_i (
    .clk(clk), .rst_n(rst_n), .slow_mul_i(slow_mul_i),
    .uop_valid_i(uop_valid_i), .uop_class_i(uop_class_i),
    .uop_rs1_i(uop_rs1_i), .uop_rs2_i(uop_rs2_i), .uop_rd_i(uop_rd_i),
    .uop_last_i(uop_last_i), .wb_valid_i(wb_valid_i), .wb_rd_i(wb_rd_i),
    .issue_en_o(issue_en_o), .stall_why_o(stall_why_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int occ_of(input int cls, input bit slow);
    case (cls)
      7: return slow ? 17 : 1;
      8: return slow ? 18 : 2;
      9: return 37;
      default: return 1;
    endcase
  endfunction

  task automatic present(input int cls, input int rs1, input int rs2, input int rd,
                         input bit last);
    uop_valid_i = 1'b1;
    uop_class_i = 4'(cls);
    uop_rs1_i   = 5'(rs1);
    uop_rs2_i   = 5'(rs2);
    uop_rd_i    = 5'(rd);
    uop_last_i  = last;
  endtask

  task automatic idle();
    @(negedge clk);
    uop_valid_i = 1'b0;
    wb_valid_i  = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // issue one op, then count stall cycles seen by an independent follower
  task automatic occ_run(input int cls, input bit slow, input string req);
    int stalls = 0;
    bit saw_busy_reason = 1;
    bit saw_busy_en = 1;
    @(negedge clk);
    slow_mul_i = slow;
    present(cls, 0, 0, 1, 1'b0);
    #1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      present(0, 0, 0, 2, 1'b0);
      if (i == 0) uop_valid_i = 1'b0;  // busy must not depend on valid
      #1;
      if (i > 0 && issue_en_o) break;
      if (i == 0 && issue_en_o) break;
      if (stall_why_o != 2'b01) saw_busy_reason = 0;
      if (issue_en_o) saw_busy_en = 0;
      stalls++;
    end
    chk(stalls == occ_of(cls, slow) - 1, req, stalls + 1, occ_of(cls, slow));
    if (stalls > 0)
      chk(saw_busy_reason && saw_busy_en, "R6", int'(saw_busy_reason), 1);
    idle();
  endtask

  // load to rd then consumer reading rd in the given position
  task automatic load_use(input int cls, input bit last, input int rd, input bit pos_b,
                          input bit wb, input int wbrd, input bit expect_stall,
                          input string req);
    @(negedge clk);
    present(cls, 0, 0, rd, last);
    #1;
    @(negedge clk);
    present(0, pos_b ? 0 : rd, pos_b ? rd : 0, 3, 1'b0);
    wb_valid_i = wb;
    wb_rd_i    = 5'(wbrd);
    #1;
    chk(issue_en_o == !expect_stall, req, int'(issue_en_o), int'(!expect_stall));
    chk(stall_why_o == (expect_stall ? 2'b10 : 2'b00), req,
        int'(stall_why_o), expect_stall ? 2 : 0);
    if (expect_stall) begin
      wb_valid_i = 1'b0;
      @(negedge clk);
      #1;
      chk(issue_en_o == 1'b1, "R7 distance 2", int'(issue_en_o), 1);
    end
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(issue_en_o == 1'b1 && stall_why_o == 2'b00, "R1", int'(stall_why_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(issue_en_o == 1'b1 && stall_why_o == 2'b00, "R1", int'(stall_why_o), 0);

    // R2 R3 R4 R5: every class code in both multiplier modes
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 16; c++) begin
        string req;
        if (c == 7 || c == 8) req = s ? "R3" : "R4";
        else if (c == 9)      req = "R5";
        else                  req = "R2";
        occ_run(c, bit'(s), req);
      end
    end

    // R7 R10: every destination, both source positions
    for (int rd = 0; rd < 32; rd++) begin
      for (int p = 0; p < 2; p++) begin
        load_use(2, 1'b0, rd, bit'(p), 1'b0, 0, rd != 0, rd == 0 ? "R10" : "R7");
      end
    end

    // R8: only the last load-multiple word creates the wait
    load_use(4, 1'b0, 9, 1'b0, 1'b0, 0, 1'b0, "R8 non-last");
    load_use(4, 1'b1, 9, 1'b0, 1'b0, 0, 1'b1, "R8 last");
    load_use(4, 1'b1, 10, 1'b1, 1'b0, 0, 1'b1, "R8 last rs2");

    // R9: base update and other writers never cause load-use
    load_use(6, 1'b0, 5, 1'b0, 1'b0, 0, 1'b0, "R9 base");
    load_use(0, 1'b0, 5, 1'b1, 1'b0, 0, 1'b0, "R9 alu");
    slow_mul_i = 1'b0;
    load_use(7, 1'b0, 5, 1'b0, 1'b0, 0, 1'b0, "R9 mul");

    // R11: writeback notice releases the wait, but only for the same register
    load_use(2, 1'b0, 6, 1'b0, 1'b1, 6, 1'b0, "R11 match");
    load_use(2, 1'b0, 6, 1'b0, 1'b1, 7, 1'b1, "R11 other");

    // R12: pending load with no valid candidate reports nothing
    @(negedge clk);
    present(2, 0, 0, 12, 1'b0);
    @(negedge clk);
    uop_valid_i = 1'b0;
    uop_rs1_i   = 5'd12;
    #1;
    chk(issue_en_o == 1'b1 && stall_why_o == 2'b00, "R12", int'(stall_why_o), 0);
    idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule